// File: doc/BRIEF.md
# Wormhole Router Input Stage

This block is one input port of a two-dimensional mesh switch that moves packets by wormhole switching. Flits arrive from two places: the link from the neighbouring switch and the host attached to this switch. A selector picks one of them, and a single-flit holding register captures the chosen flit. When the flit is a head, the port computes its route from the destination coordinates and the switch's own coordinates. X is resolved before Y.

The register then offers the flit either to the local host through the ejection port, or to one of four direction queues (east, west, north, south). The route chosen at the head is kept for the rest of the packet, so body and tail flits go the same way. The route is cleared when the tail leaves. All transfers use valid/ready handshakes. A flit moves on a cycle where both valid and ready are high.

Flit format, for FLIT_W = 16 and COORD_W = 4:
- bits [15:14] hold the type: 00 idle, 01 head, 10 body, 11 tail.
- In a head flit, bits [3:0] hold the destination X and bits [7:4] hold the destination Y.
- The switch's own position is set by the parameters MY_X and MY_Y. Both default to 5.

Top module: `wh_input_port`

## Requirements
- R1: After reset no output valid is high. With no host flit offered, `host_in_ready` is 1 and `nb_ready` is 0.
- R2: At a packet boundary, when both sources are valid, the neighbour is accepted (`nb_ready`=1) and the host is refused (`host_in_ready`=0). The two ready outputs are never high together.
- R3: Once a head from either source has been accepted, the other source is refused until that packet's tail has been accepted.
- R4: A head whose destination X is greater than MY_X goes to direction 0 (east). A head whose destination X is smaller goes to direction 1 (west). Y is ignored in both cases.
- R5: A head whose destination X equals MY_X goes to direction 2 (north) when its destination Y is greater than MY_Y, and to direction 3 (south) when it is smaller.
- R6: A head whose X and Y both equal the switch's own goes to the ejection port.
- R7: Body and tail flits leave on the output chosen by their packet's head, whatever bits they carry.
- R8: While the selected output holds ready low, the flit stays valid and unchanged on that output, and both input readies are 0. When ready returns, every flit leaves exactly once and in order.
- R9: An idle flit (type 00) on the selected source is accepted and dropped, and no output valid rises for it.
- R10: A flit accepted at a clock edge is offered at the output right after that edge. With the output ready, back-to-back flits pass at one per cycle.
- R11: At most one of `eject_valid` and the four `dir_valid` bits is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nb_valid | input | 1 | Neighbour link flit valid |
| nb_flit | input | FLIT_W | Neighbour link flit |
| nb_ready | output | 1 | Neighbour flit accepted this cycle |
| host_in_valid | input | 1 | Host injection flit valid |
| host_in_flit | input | FLIT_W | Host injection flit |
| host_in_ready | output | 1 | Host flit accepted this cycle |
| eject_valid | output | 1 | Flit offered to the local host |
| eject_flit | output | FLIT_W | Ejected flit |
| eject_ready | input | 1 | Host can take the ejected flit |
| dir_valid | output | 4 | One-hot request to direction queue (0 E, 1 W, 2 N, 3 S) |
| dir_flit | output | FLIT_W | Flit offered to the direction queues |
| dir_ready | input | 4 | Per-direction queue can accept |

## Verification
Single-packet heads are sent with destinations beyond, below and level with the switch on each axis, plus one at the switch itself. Together these separate the X-first ordering from the Y decision and from ejection.

Multi-flit packets carry body and tail bits that would decode to a different route. This shows whether the route is held per packet or recomputed for every flit.

Sources are made to contend in two ways: both offer a head at once, and the neighbour turns up in the middle of a host packet. These separate boundary priority from packet locking.

Stalls on a direction queue and on the ejection port, and an idle flit, show whether flits are held, duplicated, lost or wrongly forwarded.

// File: rtl/wh_input_port.sv
module wh_input_port #(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 4,
  parameter int MY_X    = 5,
  parameter int MY_Y    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nb_valid,
  input  logic [FLIT_W-1:0] nb_flit,
  output logic              nb_ready,
  input  logic              host_in_valid,
  input  logic [FLIT_W-1:0] host_in_flit,
  output logic              host_in_ready,
  output logic              eject_valid,
  output logic [FLIT_W-1:0] eject_flit,
  input  logic              eject_ready,
  output logic [3:0]        dir_valid,
  output logic [FLIT_W-1:0] dir_flit,
  input  logic [3:0]        dir_ready
);
  localparam int NDIR = 4;
  localparam int DW   = $clog2(NDIR);
  localparam logic [1:0] T_IDLE = 2'b00;
  localparam logic [1:0] T_HEAD = 2'b01;
  localparam logic [1:0] T_TAIL = 2'b11;
  localparam logic [1:0] L_NONE = 2'd0;
  localparam logic [1:0] L_NB   = 2'd1;
  localparam logic [1:0] L_HOST = 2'd2;
  localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

  logic [1:0]        lock_q;
  logic              full_q;
  logic [FLIT_W-1:0] flit_q;
  logic              rt_eject_q;
  logic [DW-1:0]     rt_dir_q;
  logic              rt_live_q;

  logic              sel_nb, sel_host, in_valid, can_take, take, load, out_ready, out_fire;
  logic [FLIT_W-1:0] in_flit;
  logic [1:0]        in_type;
  logic [COORD_W-1:0] dst_x, dst_y;
  logic              hd_eject;
  logic [DW-1:0]     hd_dir;

  assign sel_nb   = (lock_q == L_NB) || (lock_q == L_NONE && nb_valid);
  assign sel_host = (lock_q == L_HOST) || (lock_q == L_NONE && !nb_valid);
  assign in_valid = sel_nb ? nb_valid : (sel_host & host_in_valid);
  assign in_flit  = sel_nb ? nb_flit : host_in_flit;
  assign in_type  = in_flit[FLIT_W-1 -: 2];

  assign out_ready = rt_eject_q ? eject_ready : dir_ready[rt_dir_q];
  assign out_fire  = full_q & out_ready;
  assign can_take  = !full_q || out_ready;
  assign take      = in_valid & can_take;
  assign load      = take & (in_type != T_IDLE);

  assign nb_ready      = sel_nb & can_take;
  assign host_in_ready = sel_host & can_take;

  assign dst_x    = in_flit[COORD_W-1:0];
  assign dst_y    = in_flit[2*COORD_W-1:COORD_W];
  assign hd_eject = (dst_x == OWN_X) && (dst_y == OWN_Y);

  always_comb begin
    if (dst_x > OWN_X)      hd_dir = DW'(0);
    else if (dst_x < OWN_X) hd_dir = DW'(1);
    else if (dst_y > OWN_Y) hd_dir = DW'(2);
    else                    hd_dir = DW'(3);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= L_NONE;
    end else if (take && in_type == T_HEAD) begin
      lock_q <= sel_nb ? L_NB : L_HOST;
    end else if (take && in_type == T_TAIL) begin
      lock_q <= L_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      flit_q     <= '0;
      rt_eject_q <= 1'b0;
      rt_dir_q   <= '0;
      rt_live_q  <= 1'b0;
    end else begin
      if (out_fire) begin
        full_q <= 1'b0;
        if (flit_q[FLIT_W-1 -: 2] == T_TAIL) begin
          rt_live_q  <= 1'b0;
          rt_eject_q <= 1'b0;
          rt_dir_q   <= '0;
        end
      end
      if (load) begin
        full_q <= 1'b1;
        flit_q <= in_flit;
        if (in_type == T_HEAD) begin
          rt_eject_q <= hd_eject;
          rt_dir_q   <= hd_dir;
          rt_live_q  <= 1'b1;
        end
      end
    end
  end

  assign eject_valid = full_q & rt_eject_q;
  assign eject_flit  = flit_q;
  assign dir_flit    = flit_q;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign dir_valid[d] = full_q & !rt_eject_q & (rt_dir_q == DW'(d));
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eject_valid, dir_valid})); // R11
  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(nb_ready && host_in_ready)); // R2
  AST_HOST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_in_ready && host_in_valid && host_in_flit[FLIT_W-1 -: 2] == T_HEAD) |=> !nb_ready); // R3
  AST_ROUTE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && flit_q[FLIT_W-1 -: 2] != T_HEAD) |-> rt_live_q); // R7
  AST_EJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eject_valid && !eject_ready) |=> (eject_valid && $stable(eject_flit))); // R8
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dir_valid & ~dir_ready)) |=> ($stable(dir_valid) && $stable(dir_flit))); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((eject_valid && !eject_ready) || (|(dir_valid & ~dir_ready))) |-> (!nb_ready && !host_in_ready)); // R8
endmodule

// File: tb/wh_input_port_bench.sv
module wh_input_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nb_valid = 1'b0, host_in_valid = 1'b0;
  logic [15:0] nb_flit = '0, host_in_flit = '0;
  logic        nb_ready, host_in_ready, eject_valid;
  logic [15:0] eject_flit, dir_flit;
  logic        eject_ready = 1'b1;
  logic [3:0]  dir_valid;
  logic [3:0]  dir_ready = 4'hF;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wh_input_port u_wh_input_port (
    .clk(clk), .rst_n(rst_n),
    .nb_valid(nb_valid), .nb_flit(nb_flit), .nb_ready(nb_ready),
    .host_in_valid(host_in_valid), .host_in_flit(host_in_flit), .host_in_ready(host_in_ready),
    .eject_valid(eject_valid), .eject_flit(eject_flit), .eject_ready(eject_ready),
    .dir_valid(dir_valid), .dir_flit(dir_flit), .dir_ready(dir_ready));

  function automatic logic [15:0] head(input int x, input int y, input int tag);
    return {2'b01, 6'(tag), 4'(y), 4'(x)};
  endfunction
  function automatic logic [15:0] body(input int tag);
    return {2'b10, 14'(tag)};
  endfunction
  function automatic logic [15:0] tail(input int tag);
    return {2'b11, 14'(tag)};
  endfunction
  function automatic int exp_route(input int x, input int y);
    if (x > 5) return 0;
    if (x < 5) return 1;
    if (y > 5) return 2;
    if (y < 5) return 3;
    return 4;
  endfunction
  function automatic int obs();
    int n = $countones({eject_valid, dir_valid});
    if (n == 0) return 7;
    if (n > 1) return 6;
    if (eject_valid) return 4;
    for (int d = 0; d < 4; d++) if (dir_valid[d]) return d;
    return 7;
  endfunction
  function automatic logic [15:0] oflit();
    return eject_valid ? eject_flit : dir_flit;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1 outputs idle", obs(), 7);
    check("R1 host ready", host_in_ready, 1);
    check("R1 nb ready", nb_ready, 0);
  endtask

  task automatic t_route(input int x, input int y, input string req);
    int e = exp_route(x, y);
    nb_valid = 1; nb_flit = head(x, y, 3);
    #1 check({req, " accept"}, nb_ready, 1);
    tick();
    check({req, " head route"}, obs(), e);
    check({req, " head flit"}, oflit(), head(x, y, 3));
    nb_flit = tail(16'h0123);
    tick();
    check({req, " tail route"}, obs(), e);
    nb_valid = 0;
    tick();
    check({req, " drained"}, obs(), 7);
  endtask

  task automatic t_follow();
    logic [15:0] seq [4];
    int e;
    seq[0] = head(9, 2, 1); seq[1] = body(16'h0055); seq[2] = body(16'h00FF); seq[3] = tail(16'h0011);
    nb_valid = 1; nb_flit = seq[0];
    for (int i = 1; i < 5; i++) begin
      tick();
      check("R7 R10 follow east", obs(), 0);
      check("R10 one per cycle", oflit(), seq[i-1]);
      if (i < 4) nb_flit = seq[i];
    end
    nb_valid = 0;
    tick();
    e = exp_route(5, 5);
    nb_valid = 1; nb_flit = head(5, 5, 2);
    tick();
    nb_flit = body(16'h0009);
    check("R6 eject head", obs(), e);
    tick();
    nb_flit = tail(16'h0001);
    check("R7 body ejects", obs(), 4);
    tick();
    nb_valid = 0;
    check("R7 tail ejects", obs(), 4);
    tick();
  endtask

  task automatic t_priority();
    nb_valid = 1; nb_flit = head(5, 9, 4);
    host_in_valid = 1; host_in_flit = head(1, 1, 5);
    #1 check("R2 nb taken", nb_ready, 1);
    check("R2 host refused", host_in_ready, 0);
    tick();
    check("R2 nb head first", obs(), 2);
    nb_flit = tail(16'h0002);
    #1 check("R3 host waits nb tail", host_in_ready, 0);
    tick();
    check("R2 nb tail", obs(), 2);
    nb_valid = 0;
    #1 check("R2 host after boundary", host_in_ready, 1);
    tick();
    check("R2 host head west", obs(), 1);
    check("R2 host flit", oflit(), head(1, 1, 5));
    host_in_flit = tail(16'h0003);
    tick();
    host_in_valid = 0;
    tick();
  endtask

  task automatic t_lock();
    host_in_valid = 1; host_in_flit = head(5, 0, 6);
    tick();
    check("R3 host head south", obs(), 3);
    nb_valid = 1; nb_flit = head(9, 9, 7);
    host_in_flit = body(16'h0004);
    #1 check("R3 nb blocked mid packet", nb_ready, 0);
    check("R3 host continues", host_in_ready, 1);
    tick();
    check("R3 host body south", obs(), 3);
    host_in_flit = tail(16'h0005);
    #1 check("R3 nb blocked before tail", nb_ready, 0);
    tick();
    check("R3 host tail south", obs(), 3);
    host_in_valid = 0;
    #1 check("R3 nb released", nb_ready, 1);
    tick();
    check("R3 nb head east", obs(), 0);
    nb_flit = tail(16'h0006);
    tick();
    nb_valid = 0;
    tick();
  endtask

  task automatic t_stall();
    dir_ready[0] = 0;
    nb_valid = 1; nb_flit = head(9, 5, 8);
    tick();
    nb_flit = body(16'h0007);
    for (int i = 0; i < 3; i++) begin
      #1 check("R8 held valid", obs(), 0);
      check("R8 held flit", oflit(), head(9, 5, 8));
      check("R8 input blocked", nb_ready, 0);
      tick();
    end
    dir_ready[0] = 1;
    #1 check("R8 input resumes", nb_ready, 1);
    tick();
    check("R8 next flit no dup", oflit(), body(16'h0007));
    nb_flit = tail(16'h0008);
    tick();
    check("R8 tail in order", oflit(), tail(16'h0008));
    nb_valid = 0;
    tick();
    check("R8 no extra flit", obs(), 7);
    eject_ready = 0;
    nb_valid = 1; nb_flit = head(5, 5, 9);
    tick();
    nb_flit = tail(16'h0009);
    tick();
    check("R8 eject held", obs(), 4);
    check("R8 eject flit held", oflit(), head(5, 5, 9));
    eject_ready = 1;
    tick();
    nb_valid = 0;
    check("R8 eject tail", oflit(), tail(16'h0009));
    tick();
    check("R8 eject drained", obs(), 7);
  endtask

  task automatic t_idle();
    nb_valid = 1; nb_flit = {2'b00, 14'h3ABC};
    #1 check("R9 idle accepted", nb_ready, 1);
    tick();
    nb_valid = 0;
    check("R9 idle dropped", obs(), 7);
    tick();
  endtask

  initial begin
    t_reset();
    t_route(7, 1, "R4 east");
    t_route(1, 9, "R4 west");
    t_route(5, 9, "R5 north");
    t_route(5, 0, "R5 south");
    t_route(5, 5, "R6 eject");
    t_follow();
    t_priority();
    t_lock();
    t_stall();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n && $countones({eject_valid, dir_valid}) > 1) begin
    checks++;
    errors++;
    $display("FAIL R11: actual %0b expected onehot0", {eject_valid, dir_valid});
  end
endmodule